// File: doc/BRIEF.md
# Cascaded LED Sink-Driver Chain Controller

This block sits in a host chip and feeds a chain of latched, serial-in LED sink drivers. Each driver in the chain holds 16 bits, so one frame is 16 × `N_DEV` bits wide. The host hands over a whole frame on a valid/ready port. The block then shifts the frame out MSB-first on a data line and a shift-clock line. After the last bit it pulses a latch strobe and drives the active-high blanking line. The whole sequence runs from the system clock.

Every edge on the serial lines comes from cycle counters. Their lengths are derived at elaboration from the system clock period and from the driver's timing minimums, with each value rounded up to whole cycles. The derived values cover data setup and hold, clock pulse widths, the 10 MHz ceiling on the shift rate, the clock-to-strobe gap, the strobe width and the minimum blanking width. A frame can ask for the display to be blanked while its data is updated. The blanking line is then lifted only once the latch strobe has finished and the minimum blanking time has run out.

Top module: `led_chain_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `sclk_o` and `le_o` are 0, `oe_o` is 1 (display blanked), `s_ready` is 1 and `busy` is 0.
- R2: A frame is taken on a clock edge where `s_valid` and `s_ready` are both 1. From that edge `s_ready` is 0 until the update sequence ends, and `busy` is always the inverse of `s_ready`.
- R3: Each frame gives exactly 16 × `N_DEV` rising edges on `sclk_o`. The bit on `sd_o` at the k-th rising edge is `s_data[16·N_DEV−k]`, so bit `[MSB]` comes first.
- R4: Before each rising edge `sclk_o` is low for exactly LO_CYC cycles, where LO_CYC = max(⌈60 ns/T⌉, ⌈50 ns/T⌉), raised if needed so that LO_CYC + HI_CYC ≥ ⌈100 ns/T⌉ (T = clock period; 12 at the defaults). `sd_o` changes only on the edge that takes the frame or on a falling edge of `sclk_o`.
- R5: `sclk_o` is high for exactly HI_CYC = max(⌈50 ns/T⌉, ⌈20 ns/T⌉) cycles (10 at the defaults), and `sd_o` does not change while `sclk_o` is high.
- R6: `le_o` rises exactly GAP_CYC = ⌈100 ns/T⌉ cycles (20) after the last falling edge of `sclk_o`, and `sclk_o` is never high while `le_o` is high.
- R7: `le_o` stays high for exactly LE_CYC = ⌈100 ns/T⌉ cycles (20).
- R8: A frame taken with `s_blank`=1 raises `oe_o` on the accepting edge. `oe_o` stays high through the shifting and the strobe. It falls on the later of two points: the cycle after `le_o` falls, or when it has been high for BLANK_CYC = ⌈4.5 µs/T⌉ cycles (900). `s_ready` returns to 1 on that same edge.
- R9: A frame taken with `s_blank`=0 while `oe_o` is 0 leaves `oe_o` at 0 for the whole sequence. `s_ready` returns one cycle after `le_o` falls.
- R10: After reset `oe_o` stays 1 until the first frame has been latched, whatever that frame's `s_blank` value.
- R11: `s_valid`, `s_data` and `s_blank` are ignored while `busy` is 1. The shifted bits and the blanking behaviour are those of the accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Host offers a frame |
| s_ready | output | 1 | Block can take a frame |
| s_data | input | 16·N_DEV | Frame bits, MSB shifted first |
| s_blank | input | 1 | Blank the display during this update |
| busy | output | 1 | Update sequence in progress |
| sd_o | output | 1 | Serial data to the first driver |
| sclk_o | output | 1 | Shift clock, data taken on rising edge |
| le_o | output | 1 | Latch strobe, active high |
| oe_o | output | 1 | Blanking, high turns all sinks off |

## Verification
Every output is a register, so each result shows up in the cycle after the edge that causes it. `s_ready` drops one cycle after the accepting edge. A shift-clock edge follows exactly LO_CYC or HI_CYC cycles after the edge before it. The strobe follows GAP_CYC cycles after the last clock fall, and blanking lifts BLANK_CYC cycles after it rose. The bench samples on the falling clock edge, keeps run-length counters for every line, and compares each run length with the cycle count computed from the requirement formulas at the moment the line changes level. A frame queue kept at acceptance supplies the expected bits and blanking level.

// File: rtl/led_chain_pkg.sv
// Shared types and elaboration-time helpers for the LED chain controller.
// Assumes all timing inputs are positive integers in picoseconds.
package led_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_LATCH,
        ST_HOLD
    } ctrl_state_t;

    // Integer division rounded up, for turning a time into whole cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/led_phase_timer.sv
// Reloadable down-counter that times one phase of the serial sequence.
// Loading value v makes `expired` rise v cycles later.
// Assumes the load value fits in W bits.
module led_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/led_frame_shifter.sv
// Holds the accepted frame and presents it MSB-first on a registered data bit.
// `last` flags that the bit now on sd is the final one of the frame.
// Assumes FW >= 2 and that shift is never asked for on the last bit.
module led_frame_shifter #(
    parameter int FW = 32,
    localparam int IW = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          shift,
    output logic          sd,
    output logic          last
);

    logic [FW-1:0] shreg_q;
    logic [IW-1:0] remain_q;

    // Capture a frame or advance one bit towards the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            remain_q <= '0;
            sd       <= 1'b0;
        end else if (load) begin
            shreg_q  <= frame;
            remain_q <= IW'(FW - 1);
            sd       <= frame[FW-1];
        end else if (shift) begin
            shreg_q  <= {shreg_q[FW-2:0], 1'b0};
            remain_q <= remain_q - 1'b1;
            sd       <= shreg_q[FW-2];
        end
    end

    assign last = (remain_q == '0);

    // R3
    shift_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last)
        else $error("shift requested past the last frame bit");

endmodule

// File: rtl/led_blank_timer.sv
// Measures how long the blanking line has been high and reports once the
// minimum blanking width is met, so the line may be dropped on that edge.
// Assumes BLANK_CYC >= 1; the count saturates and clears while oe is low.
module led_blank_timer #(
    parameter int BLANK_CYC = 900,
    localparam int CW = $clog2(BLANK_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe,
    output logic done
);

    logic [CW-1:0] cnt_q;

    // Count cycles of blanking, holding at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !oe)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q >= CW'(BLANK_CYC - 1));

endmodule

// File: rtl/led_chain_ctrl.sv
// Top of the LED chain controller. Takes a frame on valid/ready, optionally
// raises blanking, shifts the frame out, pulses the latch strobe and then
// releases blanking. Every phase length is a whole number of clock cycles,
// derived at elaboration from the clock period and the driver minimums.
// Assumes all outputs go straight to the pads through registers.
module led_chain_ctrl
    import led_chain_pkg::*;
#(
    parameter int N_DEV     = 2,
    parameter int CLK_PS    = 5000,
    parameter int SETUP_PS  = 60000,
    parameter int HOLD_PS   = 20000,
    parameter int PW_PS     = 50000,
    parameter int MINPER_PS = 100000,
    parameter int SEP_PS    = 100000,
    parameter int LEW_PS    = 100000,
    parameter int BLANK_PS  = 4500000,
    localparam int FRAME_W  = 16 * N_DEV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [FRAME_W-1:0] s_data,
    input  logic               s_blank,
    output logic               busy,
    output logic               sd_o,
    output logic               sclk_o,
    output logic               le_o,
    output logic               oe_o
);

    localparam int HI_CYC  = max2(max2(ceil_div(PW_PS, CLK_PS), ceil_div(HOLD_PS, CLK_PS)), 1);
    localparam int LO_BASE = max2(max2(ceil_div(SETUP_PS, CLK_PS), ceil_div(PW_PS, CLK_PS)), 1);
    localparam int PER_CYC = ceil_div(MINPER_PS, CLK_PS);
    localparam int LO_CYC  = (LO_BASE + HI_CYC < PER_CYC) ? (PER_CYC - HI_CYC) : LO_BASE;
    localparam int GAP_CYC = max2(ceil_div(SEP_PS, CLK_PS), 1);
    localparam int LE_CYC  = max2(ceil_div(LEW_PS, CLK_PS), 1);
    localparam int BLK_CYC = max2(ceil_div(BLANK_PS, CLK_PS), 1);
    localparam int TMAX    = max2(max2(LO_CYC, HI_CYC), max2(GAP_CYC, LE_CYC));
    localparam int TW      = $clog2(TMAX + 1);

    ctrl_state_t   st_q, st_d;
    logic          sclk_q, sclk_d;
    logic          le_q, le_d;
    logic          oe_q, oe_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          sh_load, sh_shift, sh_last;
    logic          sd;
    logic          blank_done;

    led_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    led_frame_shifter #(.FW(FRAME_W)) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .frame (s_data),
        .shift (sh_shift),
        .sd    (sd),
        .last  (sh_last)
    );

    led_blank_timer #(.BLANK_CYC(BLK_CYC)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .oe    (oe_q),
        .done  (blank_done)
    );

    // Sequence control: choose the next state, line levels and phase reloads.
    always_comb begin
        st_d     = st_q;
        sclk_d   = sclk_q;
        le_d     = le_q;
        oe_d     = oe_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st_q)
            ST_IDLE: if (s_valid) begin
                sh_load  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(LO_CYC - 1);
                if (s_blank) oe_d = 1'b1;
                st_d     = ST_LOW;
            end
            ST_LOW: if (tmr_expired) begin
                sclk_d   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(HI_CYC - 1);
                st_d     = ST_HIGH;
            end
            ST_HIGH: if (tmr_expired) begin
                sclk_d   = 1'b0;
                tmr_load = 1'b1;
                if (sh_last) begin
                    tmr_val = TW'(GAP_CYC - 1);
                    st_d    = ST_GAP;
                end else begin
                    sh_shift = 1'b1;
                    tmr_val  = TW'(LO_CYC - 1);
                    st_d     = ST_LOW;
                end
            end
            ST_GAP: if (tmr_expired) begin
                le_d     = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(LE_CYC - 1);
                st_d     = ST_LATCH;
            end
            ST_LATCH: if (tmr_expired) begin
                le_d = 1'b0;
                st_d = ST_HOLD;
            end
            ST_HOLD: if (!oe_q || blank_done) begin
                oe_d = 1'b0;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and output registers; reset leaves the display blanked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
            oe_q   <= 1'b1;
        end else begin
            st_q   <= st_d;
            sclk_q <= sclk_d;
            le_q   <= le_d;
            oe_q   <= oe_d;
        end
    end

    assign s_ready = (st_q == ST_IDLE);
    assign busy    = (st_q != ST_IDLE);
    assign sd_o    = sd;
    assign sclk_o  = sclk_q;
    assign le_o    = le_q;
    assign oe_o    = oe_q;

    // R6
    clk_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_q && le_q))
        else $error("shift clock high during latch strobe");

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (busy && !s_ready))
        else $error("ready still high after frame accepted");

    // R4
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(sd))
        else $error("data changed with rising shift clock");

    // R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le_q) |=> le_q)
        else $error("latch strobe shorter than two cycles");

    // R8
    blank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_q) |-> blank_done)
        else $error("blanking released before minimum width");

    // R9
    no_blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_blank && !oe_q) |=> !oe_q)
        else $error("blanking raised for unblanked frame");

endmodule

// File: tb/led_chain_ctrl_tb.sv
// Self-checking bench for led_chain_ctrl: directed and random frames,
// with a falling-edge monitor that measures every phase length.
module led_chain_ctrl_tb;

    localparam int FW    = 32;
    localparam int T_PS  = 5000;
    localparam int HI    = 10;   // max(ceil(50/5), ceil(20/5))
    localparam int LO    = 12;   // max(ceil(60/5), ceil(50/5)); 12+10 >= 20
    localparam int GAP   = 20;   // ceil(100/5)
    localparam int LEW   = 20;   // ceil(100/5)
    localparam int BLANK = 900;  // ceil(4500/5)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [FW-1:0] s_data = '0;
    logic          s_blank = 1'b0;
    logic          busy, sd_o, sclk_o, le_o, oe_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    led_chain_ctrl #(.N_DEV(2), .CLK_PS(T_PS)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .s_blank (s_blank),
        .busy    (busy),
        .sd_o    (sd_o),
        .sclk_o  (sclk_o),
        .le_o    (le_o),
        .oe_o    (oe_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [FW-1:0] rand_frame();
        logic [FW-1:0] d = '0;
        for (int i = 0; i < FW; i += 32) d = (d << 32) | FW'($urandom);
        return d;
    endfunction

    // Expected frames, pushed at acceptance and popped when the strobe ends.
    logic [FW-1:0] exp_d[$];
    bit            exp_b[$];

    // Monitor state.
    bit            mon_on = 0;
    logic          p_sclk, p_le, p_oe, p_ready, p_sd;
    int            pc = 0, le_run = 0, oe_run = 0, nbits = 0, frames_done = 0, busy_bad = 0;
    bit            oe_from_rise = 0, le_done = 0;
    logic [FW-1:0] cap = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            bit s_rise, s_fall, r_fall, want_oe;
            s_rise = sclk_o && !p_sclk;
            s_fall = !sclk_o && p_sclk;
            r_fall = p_ready && !s_ready;
            if (busy == s_ready) busy_bad++;
            if (sd_o != p_sd) chk(s_fall || r_fall, "R4 R5 data change point", {63'd0, sclk_o}, 64'd0);
            if (s_rise) begin
                chk(pc == LO, "R4 low phase", pc, LO);
                chk(!le_o, "R6 clock during strobe", le_o, 0);
                want_oe = (exp_b.size() > 0 && exp_b[0]) || (frames_done == 0);
                chk(oe_o == want_oe, "R8 R9 R10 blanking while shifting", oe_o, want_oe);
                cap = {cap[FW-2:0], sd_o};
                nbits++;
            end
            if (s_fall) chk(pc == HI, "R5 high phase", pc, HI);
            if (le_o && !p_le) begin
                chk(pc == GAP, "R6 clock-to-strobe gap", pc, GAP);
                chk(nbits == FW, "R3 bit count", nbits, FW);
                chk(exp_d.size() > 0 && cap == exp_d[0], "R3 R11 frame bits", cap,
                    exp_d.size() > 0 ? exp_d[0] : '0);
                nbits = 0;
            end
            if (!le_o && p_le) begin
                chk(le_run == LEW, "R7 strobe width", le_run, LEW);
                le_done = 1;
                if (exp_d.size() > 0) begin
                    void'(exp_d.pop_front());
                    void'(exp_b.pop_front());
                end
                frames_done++;
            end
            if (oe_o && !p_oe) oe_from_rise = 1;
            if (!oe_o && p_oe) begin
                chk(le_done, "R8 R10 blanking held until strobe done", le_done, 1);
                if (oe_from_rise) chk(oe_run == BLANK, "R8 blanking width", oe_run, BLANK);
                chk(s_ready, "R8 ready with blanking release", s_ready, 1);
            end
            if (r_fall) le_done = 0;
            pc     = (sclk_o != p_sclk || r_fall) ? 1 : pc + 1;
            le_run = (le_o != p_le) ? 1 : le_run + 1;
            oe_run = (oe_o != p_oe) ? 1 : oe_run + 1;
        end
        p_sclk = sclk_o; p_le = le_o; p_oe = oe_o; p_ready = s_ready; p_sd = sd_o;
    end

    task automatic send(input logic [FW-1:0] d, input bit b, input int junk);
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_blank = b;
        while (!s_ready) @(negedge clk);
        exp_d.push_back(d);
        exp_b.push_back(b);
        @(negedge clk);
        chk(!s_ready && busy, "R2 ready drops on accept", {s_ready, busy}, 2'b01);
        if (junk > 0) begin
            // R11: changed inputs while busy must have no effect
            s_data = ~d; s_blank = !b;
            repeat (junk) @(negedge clk);
        end
        s_valid = 1'b0; s_data = rand_frame(); s_blank = $urandom_range(1);
    endtask

    initial begin
        repeat (3000000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk(!sclk_o && !le_o && oe_o && s_ready && !busy, "R1 reset levels",
            {sclk_o, le_o, oe_o, s_ready, busy}, 5'b00110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sclk_o && !le_o && oe_o && s_ready && !busy, "R1 after reset",
            {sclk_o, le_o, oe_o, s_ready, busy}, 5'b00110);
        mon_on = 1;
        // R10: first frame unblanked, display stays dark until it is latched
        send(32'hA5C3_0F01, 1'b0, 0);
        send('1, 1'b1, 0);
        send('0, 1'b0, 0);
        send(32'h8000_0001, 1'b1, 80);
        send(32'h5555_AAAA, 1'b0, 40);
        for (int i = 0; i < 6; i++) send(rand_frame(), $urandom_range(1), $urandom_range(1) * 60);
        while (!(s_ready && exp_d.size() == 0)) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(busy_bad == 0, "R2 busy is inverse of ready", busy_bad, 0);
        chk(frames_done == 11, "R3 all frames latched", frames_done, 11);
        chk(!oe_o && !sclk_o && !le_o, "R8 idle levels after release", {oe_o, sclk_o, le_o}, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule